// File: doc/BRIEF.md
# Daisy-Chainable 24-Bit Serial Command Slave

This block is the serial front end of a command-driven peripheral. A host drives a serial clock, an active-low select and a data line. Each bit on the data line enters a 24-bit shift register. The most significant bit of that register is driven back out on the serial output. Because of this, the output of one device can feed the data input of the next, and the bits a device pushes out are the bits it held before. A chain of N devices is updated with 24·N clocks inside one select window, and each device keeps the last 24 bits it received.

All three serial lines are oversampled by the system clock. Each line passes through a two-flop synchroniser followed by edge detection. When the select line rises, the block checks the number of bits in the window. If that count is a nonzero multiple of 24, the block issues a one-cycle frame strobe and presents the received word to the command executor. Otherwise the frame is dropped. The executor may answer the strobe with a pending readback word. That word is then shifted out during the next window. The open-drain output is modelled as a data value plus an output enable.

Top module: `spi_chain_slave`

## Requirements
- R1: While reset is asserted and directly after its release, sdo_oe_o is 0, frm_vld_o is 0, frm_word_o is 0, and the shift register holds all zeros.
- R2: In an open window, the block samples sdi_i on each rising edge of sclk_i into bit 0 of the shift register, after shifting the register up one place. An accepted frame word therefore holds the last 24 bits received, and the earliest of those bits sits at bit 23.
- R3: The serial output first presents register bit 23 when csn_i falls. On each falling edge of sclk_i, it presents the new bit 23. The output bits in a window are therefore the 24 previously held bits followed by the received bits, in order, each delayed by 24 clocks. The output holds its value at all other times.
- R4: sdo_oe_o is 1 throughout a window opened by a high-to-low transition of csn_i. It is 0 whenever csn_i is high.
- R5: When csn_i rises, a frame is accepted only if the window contained a nonzero multiple of 24 rising sclk_i edges. Acceptance gives a single-cycle frm_vld_o pulse, and frm_word_o takes the register contents at that moment.
- R6: A window with zero rising sclk_i edges, or with a count that is not a multiple of 24, gives no frm_vld_o pulse and leaves frm_word_o unchanged.
- R7: If csn_i is already low when reset is released, the block ignores clocks in that window and accepts nothing until a high-to-low transition of csn_i occurs.
- R8: If rd_pend_i is 1 in the cycle where frm_vld_o is 1, the shift register is loaded with rd_word_i. Otherwise the register keeps the received word, and that word is shifted out in the next window.
- R9: sclk_i and sdi_i activity while csn_i is high leaves the shift register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low select from the host |
| sdi_i | input | 1 | Serial data in, MSB first |
| rd_pend_i | input | 1 | Executor has a readback word to send in the next window |
| rd_word_i | input | 24 | Readback word loaded on frame acceptance |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output enable of the open-drain serial output |
| frm_vld_o | output | 1 | One-cycle strobe for an accepted frame |
| frm_word_o | output | 24 | Last accepted 24-bit word |

## Verification
The embedded properties check the following on every cycle: the output enable drops once the select is seen high, and the serial output moves only on a select fall or a clock fall. They also check that a strobe always follows a select rise, that the accepted word never changes without a strobe, that the shift register stays fixed while deselected, that a readback word lands in the register after a strobe, and that the bit counter stays in range. Only the bench scenarios can show the ordering that makes chaining work. A sweep of window lengths from 0 to 72 bits compares every output bit against the 24-clock delayed input and separates accepted multiples of 24 from dropped counts. Further scenarios cover arming after reset with the select already low, and readback words appearing in the following window.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

  localparam int unsigned FRAME_BITS = 24;

  // synchronised level of one serial line plus its edges
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } edge_t;

endpackage

// File: rtl/spi_chain_sync.sv
module spi_chain_sync
  import spi_chain_pkg::*;
#(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  din,
  output edge_t ev
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_n;
  logic              prev_q;
  logic              prev_n;

  always_comb begin
    pipe_n = {pipe_q[STAGES-2:0], din};
    prev_n = pipe_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      pipe_q <= pipe_n;
      prev_q <= prev_n;
    end
  end

  always_comb begin
    ev.lvl  = pipe_q[STAGES-1];
    ev.rise = pipe_q[STAGES-1] & ~prev_q;
    ev.fall = ~pipe_q[STAGES-1] & prev_q;
  end

endmodule

// File: rtl/spi_chain_framer.sv
module spi_chain_framer
  import spi_chain_pkg::*;
#(
  parameter int unsigned WORD_W = FRAME_BITS
) (
  input  logic  clk,
  input  logic  rst_n,
  input  edge_t cs_ev,
  input  edge_t sclk_ev,
  output logic  in_frame_o,
  output logic  shift_en_o,
  output logic  present_o,
  output logic  accept_o
);

  localparam int unsigned CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic          in_q,   in_n;
  logic          wrap_q, wrap_n;
  logic [CW-1:0] cnt_q,  cnt_n;

  // strobes toward the shifter and the output stage
  always_comb begin
    shift_en_o = in_q & ~cs_ev.lvl & sclk_ev.rise;
    present_o  = cs_ev.fall | (in_q & ~cs_ev.lvl & sclk_ev.fall);
    accept_o   = in_q & cs_ev.rise & wrap_q & (cnt_q == '0);
    in_frame_o = in_q;
  end

  // window and bit-count next state
  always_comb begin
    in_n   = in_q;
    wrap_n = wrap_q;
    cnt_n  = cnt_q;
    if (cs_ev.fall) begin
      in_n   = 1'b1;
      wrap_n = 1'b0;
      cnt_n  = '0;
    end else if (cs_ev.rise) begin
      in_n   = 1'b0;
    end else if (shift_en_o) begin
      if (cnt_q == LAST) begin
        cnt_n  = '0;
        wrap_n = 1'b1;
      end else begin
        cnt_n  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= 1'b0;
      wrap_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      in_q   <= in_n;
      wrap_q <= wrap_n;
      cnt_q  <= cnt_n;
    end
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R7
  frame_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_q) |-> $past(cs_ev.fall));

endmodule

// File: rtl/spi_chain_shifter.sv
module spi_chain_shifter #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              sdi_bit,
  input  logic              present,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_word,
  output logic [WORD_W-1:0] word_o,
  output logic              sdo_o
);

  logic [WORD_W-1:0] sr_q, sr_n;
  logic              sdo_q, sdo_n;

  always_comb begin
    sr_n = sr_q;
    if (load_en) begin
      sr_n = load_word;
    end else if (shift_en) begin
      sr_n = {sr_q[WORD_W-2:0], sdi_bit};
    end
  end

  always_comb begin
    sdo_n = sdo_q;
    if (present) begin
      sdo_n = sr_q[WORD_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      sdo_q <= 1'b0;
    end else begin
      sr_q  <= sr_n;
      sdo_q <= sdo_n;
    end
  end

  assign word_o = sr_q;
  assign sdo_o  = sdo_q;

endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
  import spi_chain_pkg::*;
#(
  parameter int unsigned WORD_W      = FRAME_BITS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  input  logic              rd_pend_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              frm_vld_o,
  output logic [WORD_W-1:0] frm_word_o
);

  localparam int unsigned N_LINES = 3;
  localparam int unsigned L_SCLK  = 0;
  localparam int unsigned L_CS    = 1;
  localparam int unsigned L_SDI   = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sn = rst_pipe_q[1];

  // line synchronisers; reset to low so a select held low at reset shows no fall
  logic [N_LINES-1:0] raw;
  edge_t              ev [N_LINES];

  assign raw[L_SCLK] = sclk_i;
  assign raw[L_CS]   = csn_i;
  assign raw[L_SDI]  = sdi_i;

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    spi_chain_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
    ) u_sync (
      .clk   (clk),
      .rst_n (rst_sn),
      .din   (raw[g]),
      .ev    (ev[g])
    );
  end

  edge_t ev_sclk, ev_cs, ev_sdi;
  assign ev_sclk = ev[L_SCLK];
  assign ev_cs   = ev[L_CS];
  assign ev_sdi  = ev[L_SDI];

  logic in_frame, shift_en, present, accept;

  spi_chain_framer #(
    .WORD_W (WORD_W)
  ) u_framer (
    .clk        (clk),
    .rst_n      (rst_sn),
    .cs_ev      (ev_cs),
    .sclk_ev    (ev_sclk),
    .in_frame_o (in_frame),
    .shift_en_o (shift_en),
    .present_o  (present),
    .accept_o   (accept)
  );

  logic              frm_vld_q, frm_vld_n;
  logic [WORD_W-1:0] frm_word_q, frm_word_n;
  logic [WORD_W-1:0] sr_word;
  logic              load_en;

  assign load_en = frm_vld_q & rd_pend_i;

  spi_chain_shifter #(
    .WORD_W (WORD_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_sn),
    .shift_en  (shift_en),
    .sdi_bit   (ev_sdi.lvl),
    .present   (present),
    .load_en   (load_en),
    .load_word (rd_word_i),
    .word_o    (sr_word),
    .sdo_o     (sdo_o)
  );

  always_comb begin
    frm_vld_n  = accept;
    frm_word_n = frm_word_q;
    if (accept) begin
      frm_word_n = sr_word;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      frm_vld_q  <= 1'b0;
      frm_word_q <= '0;
    end else begin
      frm_vld_q  <= frm_vld_n;
      frm_word_q <= frm_word_n;
    end
  end

  assign frm_vld_o  = frm_vld_q;
  assign frm_word_o = frm_word_q;
  assign sdo_oe_o   = in_frame;

  // R4
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ev_cs.lvl |=> !sdo_oe_o);

  // R3
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!ev_cs.fall && !ev_sclk.fall) |=> $stable(sdo_o));

  // R5
  vld_src_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    frm_vld_o |-> $past(ev_cs.rise));

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !frm_vld_o |-> $stable(frm_word_o));

  // R8
  rd_load_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (frm_vld_o && rd_pend_i) |=> (sr_word == $past(rd_word_i)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (ev_cs.lvl && !frm_vld_o) |=> $stable(sr_word));

endmodule

// File: tb/sim_spi_chain_slave.sv
module sim_spi_chain_slave;

  localparam int H = 4;

  logic        clk = 1'b0;
  logic        rst_n, sclk, csn, sdi, rd_pend;
  logic [23:0] rd_word;
  logic        sdo_o, sdo_oe_o, frm_vld_o;
  logic [23:0] frm_word_o;

  always #4 clk = ~clk;

  spi_chain_slave u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_i     (sclk),
    .csn_i      (csn),
    .sdi_i      (sdi),
    .rd_pend_i  (rd_pend),
    .rd_word_i  (rd_word),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o),
    .frm_vld_o  (frm_vld_o),
    .frm_word_o (frm_word_o)
  );

  int          vectors = 0;
  int          miscompares = 0;
  int          vld_cnt = 0;
  bit          done = 0;
  logic [23:0] model;

  always @(posedge clk) begin
    if (frm_vld_o) vld_cnt <= vld_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] pat(input int seed);
    logic [31:0] x;
    logic [95:0] r;
    x = 32'(seed) * 32'd2654435761 + 32'd12345;
    for (int k = 0; k < 3; k++) begin
      x = x * 32'd1103515245 + 32'd12345;
      r[k*32 +: 32] = x;
    end
    return r;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one select window of n bits, MSB first from d[n-1]
  task automatic frame(input logic [95:0] d, input int n, input string sdo_req);
    logic [95:0] got;
    logic [95:0] exp;
    int          v0;
    logic [23:0] w0;
    bit          oe_bad;
    got = '0; exp = '0; oe_bad = 0;
    v0 = vld_cnt; w0 = frm_word_o;
    csn = 1'b0;
    wait_n(2*H);
    if (!sdo_oe_o) oe_bad = 1;
    for (int i = 0; i < n; i++) begin
      got[n-1-i] = sdo_o;
      if (!sdo_oe_o) oe_bad = 1;
      exp[n-1-i] = model[23];
      model = {model[22:0], d[n-1-i]};
      sdi = d[n-1-i];
      wait_n(H);
      sclk = 1'b1;
      wait_n(H);
      sclk = 1'b0;
      wait_n(H);
    end
    wait_n(H);
    csn = 1'b1;
    wait_n(3*H);
    if (n > 0) chk(got == exp, sdo_req, got, exp);
    chk(!oe_bad, "R4 enable in window", {95'd0, !oe_bad}, 96'd1);
    chk(!sdo_oe_o, "R4 enable after window", {95'd0, sdo_oe_o}, 96'd0);
    if (n > 0 && n % 24 == 0) begin
      chk(vld_cnt == v0 + 1, "R5 one strobe", 96'(vld_cnt - v0), 96'd1);
      chk(frm_word_o == model, "R2 frame word", {72'd0, frm_word_o}, {72'd0, model});
      if (rd_pend) model = rd_word;
    end else begin
      chk(vld_cnt == v0, "R6 no strobe", 96'(vld_cnt - v0), 96'd0);
      chk(frm_word_o == w0, "R6 word held", {72'd0, frm_word_o}, {72'd0, w0});
    end
  endtask

  initial begin
    bit oe_seen;
    rst_n = 1'b0; csn = 1'b0; sclk = 1'b0; sdi = 1'b0;
    rd_pend = 1'b0; rd_word = '0; model = '0;
    wait_n(5);
    chk(!sdo_oe_o && !frm_vld_o && frm_word_o == 0, "R1 in reset",
        {70'd0, sdo_oe_o, frm_vld_o, frm_word_o}, 96'd0);
    rst_n = 1'b1;
    wait_n(5);
    chk(!sdo_oe_o && !frm_vld_o && frm_word_o == 0, "R1 after reset",
        {70'd0, sdo_oe_o, frm_vld_o, frm_word_o}, 96'd0);

    // R7: select low since reset, 24 clocks must not count
    oe_seen = 0;
    for (int i = 0; i < 24; i++) begin
      sdi = 1'b1;
      wait_n(H); sclk = 1'b1; wait_n(H); sclk = 1'b0; wait_n(H);
      if (sdo_oe_o) oe_seen = 1;
    end
    csn = 1'b1;
    wait_n(3*H);
    chk(vld_cnt == 0, "R7 no frame before arming", 96'(vld_cnt), 96'd0);
    chk(!oe_seen, "R7 enable stays off", {95'd0, oe_seen}, 96'd0);
    frame(pat(500), 24, "R7 register untouched");

    // window-length sweep 0..72
    for (int n = 0; n <= 72; n++) begin
      frame(pat(n), n, "R3 chained output");
    end

    // R9: clocks while deselected
    sdi = 1'b1;
    for (int i = 0; i < 30; i++) begin
      wait_n(H); sclk = 1'b1; wait_n(H); sclk = 1'b0;
    end
    sdi = 1'b0;
    wait_n(H);
    frame(pat(200), 24, "R9 idle clocks ignored");

    // R8: readback words
    rd_pend = 1'b1;
    for (int k = 0; k < 6; k++) begin
      rd_word = pat(300 + k)[23:0];
      frame(pat(310 + k), (k % 2 == 0) ? 24 : 48, "R8 readback shifted");
    end
    rd_word = 24'hC35A96;
    frame(pat(320), 23, "R8 readback");
    frame(pat(321), 24, "R8 no load after dropped frame");
    rd_pend = 1'b0;
    frame(pat(322), 24, "R8 readback");
    frame(pat(323), 24, "R8 received word kept");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=done", vectors);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule